// File: doc/BRIEF.md
# Missing Clock Detector with Failover

This block guards a primary oscillator clock. It compares that clock with a backup reference clock that always runs. A small counter clocked by the primary clock wraps every 128 primary edges. Each wrap flips a toggle, which is carried into the reference domain. There, every toggle edge restarts a 13-bit window counter. If the window counter completes 8192 reference cycles without a restart, the primary clock is treated as missing. This happens when the primary clock has stopped, or when it runs slower than the reference by a factor of about 64 or more.

A detection sets a sticky flag, which also drives the clock-fail output. While the flag is set, the window counter freezes. The block also forces three outputs: the effective clock-source select goes to the backup code, PLL bypass goes high, and the effective PLL multiplier reads zero. Software re-arms the block with a write-one-to-clear strobe. The strobe clears the flag, restarts the window, and resets the primary counter through its asynchronous reset, so the clear works even when the primary clock is dead. A disable input pauses monitoring. Monitoring is enabled out of reset.

Top module: `mcd_failover`

## Requirements
- R1: While the primary clock period is at most 63 reference periods (including primary clocks faster than the reference), the flag and clock-fail stay low indefinitely.
- R2: With a primary clock period of 65 reference periods, the flag and clock-fail go high.
- R3: With the primary clock stopped, the flag rises on the 8193rd rising reference edge after the edge that samples the clear strobe. After the primary clock stops at an arbitrary moment, the flag rises within 8200 reference cycles.
- R4: Once set, the flag and clock-fail stay high while no clear is given, even if the primary clock resumes at a healthy rate. Clock-fail always equals the flag.
- R5: While the flag is high, three outputs are forced regardless of the software inputs: the effective source select equals the backup code (default 0), pll_bypass is 1, and the effective multiplier is 0.
- R6: While the flag is low, the effective source select follows sw_src_sel, the effective multiplier follows sw_pll_mult, and pll_bypass is 0.
- R7: A clear strobe that is high at one reference edge makes the flag low after the next reference edge.
- R8: If a clear strobe is registered at the same edge at which the window counter would overflow, the clear wins. The flag stays low, and a fresh 8192-cycle window starts from that edge.
- R9: While mon_off is 1, no new detection occurs, whatever the primary clock does. A flag that is already set stays set until cleared. After mon_off returns to 0 with the primary clock stopped, the flag rises within 8200 reference cycles.
- R10: During reset and after reset is released, the flag is low, the outputs pass through the software values, and monitoring is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pri | input | 1 | Primary oscillator clock under watch |
| clk_ref | input | 1 | Backup reference clock, always running |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_off | input | 1 | 1 pauses monitoring (clk_ref domain) |
| clr_w1c | input | 1 | One-cycle clear strobe (clk_ref domain) |
| sw_src_sel | input | SEL_W | Software clock-source select |
| sw_pll_mult | input | MULT_W | Software PLL multiplier |
| mcd_flag | output | 1 | Sticky missing-clock flag |
| clk_fail | output | 1 | Clock-fail indication |
| eff_src_sel | output | SEL_W | Effective source select after override |
| pll_bypass | output | 1 | Forced PLL bypass |
| eff_pll_mult | output | MULT_W | Effective PLL multiplier after override |

## Verification
The delicate collision is a clear strobe that is registered on the very edge where the window counter would overflow. The bench stops the primary clock, issues a clear, and counts reference edges so that a second clear lands on the 8192nd edge of the window. It then checks that the flag is still low one edge later. It also checks that the next detection comes exactly 8193 edges after that second clear, which shows the clear both won and restarted the window.

// File: rtl/mcd_pkg.sv
package mcd_pkg;
  // Default geometry of the ratio watchdog
  localparam int unsigned PRI_W_DEF   = 7;   // primary wrap every 2**7 edges
  localparam int unsigned REF_W_DEF   = 13;  // reference window of 2**13 cycles
  localparam int unsigned SYNC_N_DEF  = 2;   // synchronizer depth
  localparam int unsigned SEL_W_DEF   = 2;
  localparam int unsigned MULT_W_DEF  = 7;
endpackage

// File: rtl/mcd_rst_sync.sv
module mcd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  always_comb begin
    sr_d = {sr_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sr_q <= '0;
    else         sr_q <= sr_d;
  end

  assign rst_n_o = sr_q[STAGES-1];
endmodule

// File: rtl/mcd_sync_bits.sv
module mcd_sync_bits #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned W      = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  always_comb begin
    stg_d[0] = d_i;
    for (int s = 1; s < STAGES; s++) stg_d[s] = stg_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/mcd_pri_cnt.sv
module mcd_pri_cnt #(
  parameter int unsigned PRI_W = 7
) (
  input  logic clk_pri,
  input  logic cnt_arst_n,   // system reset or software clear
  input  logic tog_arst_n,   // system reset only
  output logic tog_o
);
  localparam logic [PRI_W-1:0] PRI_ONE = {{(PRI_W-1){1'b0}}, 1'b1};

  logic [PRI_W-1:0] cnt_q, cnt_d;
  logic             tog_q, tog_d;
  logic             wrap;

  always_comb begin
    wrap  = &cnt_q;
    cnt_d = cnt_q + PRI_ONE;
    tog_d = tog_q ^ wrap;
  end

  always_ff @(posedge clk_pri or negedge cnt_arst_n) begin
    if (!cnt_arst_n) cnt_q <= '0;
    else             cnt_q <= cnt_d;
  end

  always_ff @(posedge clk_pri or negedge tog_arst_n) begin
    if (!tog_arst_n) tog_q <= 1'b0;
    else             tog_q <= tog_d;
  end

  assign tog_o = tog_q;

  // R1
  tog_on_wrap_chk: assert property (@(posedge clk_pri) disable iff (!tog_arst_n)
    (tog_q != $past(tog_q)) |-> $past(wrap));
endmodule

// File: rtl/mcd_ref_watch.sv
module mcd_ref_watch #(
  parameter int unsigned REF_W  = 13,
  parameter int unsigned STAGES = 2
) (
  input  logic clk_ref,
  input  logic rst_n,
  input  logic tog_i,
  input  logic mon_off_i,
  input  logic clr_i,
  output logic flag_o,
  output logic clr_q_o
);
  localparam logic [REF_W-1:0] CNT_MAX = {REF_W{1'b1}};
  localparam logic [REF_W-1:0] REF_ONE = {{(REF_W-1){1'b0}}, 1'b1};

  logic             tog_s, tog_last_q;
  logic             tog_edge;
  logic             clr_q;
  logic [REF_W-1:0] cnt_q, cnt_d;
  logic             flag_q, flag_d;
  logic             ovf;

  mcd_sync_bits #(.STAGES(STAGES), .W(1)) u_tog_sync (
    .clk   (clk_ref),
    .rst_n (rst_n),
    .d_i   (tog_i),
    .q_o   (tog_s)
  );

  always_comb begin
    tog_edge = tog_s ^ tog_last_q;
    cnt_d    = cnt_q;
    flag_d   = flag_q;
    ovf      = 1'b0;
    if (clr_q) begin
      cnt_d  = '0;
      flag_d = 1'b0;
    end else if (mon_off_i) begin
      cnt_d  = '0;
    end else if (!flag_q) begin
      if (tog_edge) begin
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + REF_ONE;
        ovf   = (cnt_q == CNT_MAX);
        if (ovf) flag_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      tog_last_q <= 1'b0;
      clr_q      <= 1'b0;
      cnt_q      <= '0;
      flag_q     <= 1'b0;
    end else begin
      tog_last_q <= tog_s;
      clr_q      <= clr_i;
      cnt_q      <= cnt_d;
      flag_q     <= flag_d;
    end
  end

  assign flag_o  = flag_q;
  assign clr_q_o = clr_q;

  // R3
  flag_rise_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(flag_q) |-> ($past(cnt_q) == CNT_MAX) && !$past(tog_edge) && !$past(mon_off_i));
  // R4
  flag_sticky_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (flag_q && !clr_q) |=> flag_q);
  // R7
  flag_fall_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $fell(flag_q) |-> $past(clr_q));
  // R8
  clear_wins_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    clr_q |=> (!flag_q && cnt_q == '0));
  // R9
  off_holds_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (mon_off_i && !flag_q) |=> !flag_q);
endmodule

// File: rtl/mcd_failover.sv
module mcd_failover
  import mcd_pkg::*;
#(
  parameter int unsigned PRI_W  = PRI_W_DEF,
  parameter int unsigned REF_W  = REF_W_DEF,
  parameter int unsigned SYNC_N = SYNC_N_DEF,
  parameter int unsigned SEL_W  = SEL_W_DEF,
  parameter int unsigned MULT_W = MULT_W_DEF,
  parameter logic [SEL_W-1:0] BACKUP_SEL = '0
) (
  input  logic              clk_pri,
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic              mon_off,
  input  logic              clr_w1c,
  input  logic [SEL_W-1:0]  sw_src_sel,
  input  logic [MULT_W-1:0] sw_pll_mult,
  output logic              mcd_flag,
  output logic              clk_fail,
  output logic [SEL_W-1:0]  eff_src_sel,
  output logic              pll_bypass,
  output logic [MULT_W-1:0] eff_pll_mult
);
  logic ref_rst_n;
  logic clr_q;
  logic pri_cnt_arst_n;
  logic pri_tog;
  logic flag;

  mcd_rst_sync #(.STAGES(SYNC_N)) u_ref_rst (
    .clk     (clk_ref),
    .arst_n  (rst_n),
    .rst_n_o (ref_rst_n)
  );

  assign pri_cnt_arst_n = rst_n & ~clr_q;

  mcd_pri_cnt #(.PRI_W(PRI_W)) u_pri_cnt (
    .clk_pri    (clk_pri),
    .cnt_arst_n (pri_cnt_arst_n),
    .tog_arst_n (rst_n),
    .tog_o      (pri_tog)
  );

  mcd_ref_watch #(.REF_W(REF_W), .STAGES(SYNC_N)) u_ref_watch (
    .clk_ref   (clk_ref),
    .rst_n     (ref_rst_n),
    .tog_i     (pri_tog),
    .mon_off_i (mon_off),
    .clr_i     (clr_w1c),
    .flag_o    (flag),
    .clr_q_o   (clr_q)
  );

  always_comb begin
    mcd_flag     = flag;
    clk_fail     = flag;
    eff_src_sel  = flag ? BACKUP_SEL : sw_src_sel;
    pll_bypass   = flag;
    eff_pll_mult = flag ? '0 : sw_pll_mult;
  end
endmodule

// File: tb/test_mcd_failover.sv
`timescale 1ns/1ps
module test_mcd_failover;
  logic       clk_pri, clk_ref, rst_n, mon_off, clr_w1c;
  logic [1:0] sw_src_sel;
  logic [6:0] sw_pll_mult;
  logic       mcd_flag, clk_fail, pll_bypass;
  logic [1:0] eff_src_sel;
  logic [6:0] eff_pll_mult;

  int  n_cmp = 0;
  int  n_bad = 0;
  real pri_half = 17.5;
  bit  pri_run  = 1'b1;

  mcd_failover i_mcd_failover (
    .clk_pri(clk_pri), .clk_ref(clk_ref), .rst_n(rst_n), .mon_off(mon_off),
    .clr_w1c(clr_w1c), .sw_src_sel(sw_src_sel), .sw_pll_mult(sw_pll_mult),
    .mcd_flag(mcd_flag), .clk_fail(clk_fail), .eff_src_sel(eff_src_sel),
    .pll_bypass(pll_bypass), .eff_pll_mult(eff_pll_mult));

  initial begin clk_ref = 1'b0; forever #2.5 clk_ref = ~clk_ref; end

  initial begin
    clk_pri = 1'b0;
    forever begin
      if (pri_run) begin #(pri_half) clk_pri = ~clk_pri; end
      else begin clk_pri = 1'b0; #1; end
    end
  end

  function automatic logic [9:0] exp_outs(bit flag, logic [1:0] sel, logic [6:0] mult);
    return flag ? {2'b00, 1'b1, 7'd0} : {sel, 1'b0, mult};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_all(string req, bit flag);
    chk({req, " flag"}, {31'd0, mcd_flag}, {31'd0, flag});
    chk({req, " clk_fail"}, {31'd0, clk_fail}, {31'd0, flag});
    chk({req, " outs"}, {22'd0, eff_src_sel, pll_bypass, eff_pll_mult},
        {22'd0, exp_outs(flag, sw_src_sel, sw_pll_mult)});
  endtask

  task automatic wait_ref(int n);
    repeat (n) @(negedge clk_ref);
  endtask

  task automatic pulse_clear();
    @(negedge clk_ref); clr_w1c = 1'b1;
    @(negedge clk_ref); clr_w1c = 1'b0;
  endtask

  task automatic new_sw();
    sw_src_sel  = 2'($urandom);
    sw_pll_mult = 7'($urandom);
  endtask

  task automatic set_ratio(real r);
    pri_half = r * 2.5;
    pri_run  = 1'b1;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #900000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int waited;
    void'($urandom(32'd1234));
    rst_n = 1'b0; mon_off = 1'b0; clr_w1c = 1'b0;
    new_sw();
    set_ratio(7.0);
    wait_ref(5);
    chk_all("R10 in reset", 1'b0);
    rst_n = 1'b1;
    wait_ref(3);
    chk_all("R10 after reset", 1'b0);

    // R1 / R6: random healthy ratios, software values pass through
    for (int it = 0; it < 4; it++) begin
      if (it == 0) set_ratio(0.37);
      else set_ratio(real'(1 + $urandom % 50) + real'($urandom % 100) / 100.0);
      for (int k = 0; k < 12; k++) begin
        new_sw();
        wait_ref(500);
        chk_all("R1 R6 healthy", 1'b0);
      end
    end

    // R1 boundary: ratio 63
    set_ratio(63.0);
    for (int k = 0; k < 4; k++) begin
      wait_ref(5000);
      chk_all("R1 ratio 63", 1'b0);
    end

    // R2: ratio 65 must be detected
    set_ratio(65.0);
    waited = 0;
    while (!mcd_flag && waited < 30000) begin wait_ref(1); waited++; end
    chk_all("R2 ratio 65", 1'b1);
    for (int k = 0; k < 4; k++) begin
      new_sw(); wait_ref(3);
      chk_all("R5 override", 1'b1);
    end

    // R4: sticky despite healthy primary
    set_ratio(10.0);
    wait_ref(10000);
    chk_all("R4 sticky", 1'b1);

    // R7: clear
    pulse_clear();
    wait_ref(1);
    chk_all("R7 clear", 1'b0);
    wait_ref(10000);
    chk_all("R1 after clear", 1'b0);

    // R3: stop primary at arbitrary moment
    wait_ref(1 + $urandom % 300);
    pri_run = 1'b0;
    waited = 0;
    while (!mcd_flag && waited < 9000) begin wait_ref(1); waited++; end
    chk("R3 stop latency within 8200", {31'd0, (waited <= 8200)}, 32'd1);
    chk_all("R3 stopped", 1'b1);

    // R3 exact window after a clear
    pulse_clear();
    wait_ref(8192);
    chk_all("R3 edge 8192", 1'b0);
    wait_ref(1);
    chk_all("R3 edge 8193", 1'b1);

    // R8: clear collides with overflow
    pulse_clear();
    wait_ref(8190);
    pulse_clear();
    wait_ref(1);
    chk_all("R8 clear wins", 1'b0);
    wait_ref(8191);
    chk_all("R8 new window 8192", 1'b0);
    wait_ref(1);
    chk_all("R8 new window 8193", 1'b1);

    // R9: disable
    @(negedge clk_ref); mon_off = 1'b1;
    wait_ref(100);
    chk_all("R9 set flag kept", 1'b1);
    pulse_clear();
    wait_ref(1);
    chk_all("R9 clear while off", 1'b0);
    wait_ref(10000);
    chk_all("R9 no detect while off", 1'b0);
    @(negedge clk_ref); mon_off = 1'b0;
    waited = 0;
    while (!mcd_flag && waited < 9000) begin wait_ref(1); waited++; end
    chk("R9 resume latency", {31'd0, (waited <= 8200)}, 32'd1);
    chk_all("R9 resumed", 1'b1);

    finish_run();
  end
endmodule